// File: doc/BRIEF.md
# Ping-Pong De-Interlace Line Buffer

This block sits between an interlaced video decoder and a progressive display path. While one line of incoming 4:2:2 video is being captured, the line captured just before it is played out. Two line memories swap roles each time a new input line begins. Incoming bytes come one per clock in the repeating order U, Y0, V, Y1. Each pair of bytes is packed into one 16-bit word before it is stored, so a memory write happens on every second accepted byte.

On the read side the stored words are fetched one per clock and expanded to 4:4:4. One pixel leaves per clock as separate Y, U and V bytes. Both pixels of a pair share the same U and V. The display side pulses a start input at the beginning of each output line, and the stored line is replayed from its first word each time. Two pulses per input line period give line doubling without any interpolation.

A capture that runs past the end of the memory holds its pointer at the last word. The start of the stored line is therefore never overwritten. No pixel is produced until at least one complete input line has been captured.

Top module: `pingpong_deinterlace`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `out_valid` is low; reset clears both bank selects, both pointers and all pending data.
- R2: A pulse on `out_line_start` produces no output until two `in_line_start` pulses have been seen since reset, that is, until one line has been framed at both ends.
- R3: Accepted bytes are paired in arrival order. The first byte of a pair goes to bits 15:8 of a stored word and the second to bits 7:0. Within a line, word 2k holds {U, Y0} and word 2k+1 holds {V, Y1} of pixel pair k.
- R4: Pixel 2k is output as (Y0, U, V) and pixel 2k+1 as (Y1, U, V), both using the U and V of pair k. Pixels of one pass come on consecutive clocks with `out_valid` high.
- R5: A pass outputs exactly as many pixels as words were stored for the line being read, which is the number of complete byte pairs, limited to the memory depth.
- R6: The first pixel of a pass is valid on the third rising edge after the edge that samples `out_line_start` high.
- R7: Every `out_line_start` pulse replays the same stored line from word 0, until the next `in_line_start` selects a new one.
- R8: Capturing the next line never changes the line being read. On `in_line_start` the bank just written becomes the read bank, and only one bank is written in any cycle.
- R9: The write pointer stops at the last address. Bytes past the memory depth keep overwriting the last word, so words 0 up to depth-2 keep their values and the last word holds the final complete pair.
- R10: Clocks with `in_valid` low neither store a byte nor advance the byte pairing.
- R11: `in_line_start` restarts the byte pairing. A lone byte left at the end of a line is dropped, and the next line starts at word 0 with its own first byte in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock shared by capture and playout |
| rst | input | 1 | Synchronous active-high reset |
| in_line_start | input | 1 | One-clock pulse marking the start of an input line |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Interleaved 4:2:2 byte stream (U, Y0, V, Y1 ...) |
| out_line_start | input | 1 | One-clock pulse that starts playout of the stored line |
| out_valid | output | 1 | Output pixel qualifier |
| out_y | output | 8 | Luma of the output pixel |
| out_u | output | 8 | Blue-difference chroma of the output pixel |
| out_v | output | 8 | Red-difference chroma of the output pixel |

## Verification
The bench runs a 16-word configuration and feeds it lines of several lengths. Each line has distinct byte values and irregular gaps in `in_valid`, so a byte that is misplaced, dropped or paired with the wrong partner changes a compared pixel. Every line is played twice while the next line is captured, which separates a correct ping-pong swap from reading the bank being written. An over-long line shows whether the pointer saturates or wraps. An odd-length line followed by a normal one shows whether the pairing restarts at each line start. The bench also checks the pixel count of every pass and the clock on which each pixel appears. This catches both a wrong latency and a gap inside a pass.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef struct packed {
    logic [BYTE_W-1:0] y;
    logic [BYTE_W-1:0] u;
    logic [BYTE_W-1:0] v;
  } yuv_px_t;
endpackage

// File: rtl/lb_bank.sv
// One line memory: single address port, read-first, registered output.
module lb_bank #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/lb_write_ctrl.sv
// Capture side: pairs bytes into words, owns the write pointer and both selects.
module lb_write_ctrl
  import lb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              wr_sel,
  output logic              rd_sel,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              we,
  output logic [WORD_W-1:0] wdata,
  output logic [ADDR_W:0]   rd_len,
  output logic              have_line
);
  localparam int          LEN_W    = ADDR_W + 1;
  localparam int          DEPTH    = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic              armed;
  logic              phase;
  logic [BYTE_W-1:0] hold;
  logic [LEN_W-1:0]  wr_cnt;

  assign we    = byte_vld & phase & armed & ~line_start;
  assign wdata = {hold, byte_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel    <= 1'b0;
      rd_sel    <= 1'b0;
      wr_ptr    <= '0;
      wr_cnt    <= '0;
      rd_len    <= '0;
      phase     <= 1'b0;
      hold      <= '0;
      armed     <= 1'b0;
      have_line <= 1'b0;
    end else if (line_start) begin
      wr_sel    <= ~wr_sel;
      rd_sel    <= wr_sel;
      rd_len    <= wr_cnt;
      wr_ptr    <= '0;
      wr_cnt    <= '0;
      phase     <= 1'b0;
      armed     <= 1'b1;
      have_line <= armed;
    end else if (byte_vld && armed) begin
      if (!phase) begin
        hold  <= byte_in;
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (wr_ptr != LAST_ADDR) wr_ptr <= wr_ptr + 1'b1;
        if (wr_cnt != LEN_W'(DEPTH)) wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lb_read_ctrl.sv
// Playout side: walks the stored line once per start pulse.
module lb_read_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              have_line,
  input  logic [ADDR_W:0]   rd_len,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              word_vld,
  output logic              word_odd
);
  localparam int LEN_W = ADDR_W + 1;

  logic rd_act;
  logic at_last;

  assign at_last = ({1'b0, rd_ptr} == rd_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act   <= 1'b0;
      rd_ptr   <= '0;
      word_vld <= 1'b0;
      word_odd <= 1'b0;
    end else begin
      word_vld <= rd_act;
      word_odd <= rd_ptr[0];
      if (start && have_line && rd_len != '0) begin
        rd_act <= 1'b1;
        rd_ptr <= '0;
      end else if (rd_act) begin
        if (at_last) rd_act <= 1'b0;
        else         rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lb_expand.sv
// Turns {U,Y0},{V,Y1} word pairs into one Y/U/V pixel per clock.
module lb_expand
  import lb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic              word_odd,
  input  logic [WORD_W-1:0] word,
  output logic              px_vld,
  output yuv_px_t           px
);
  logic [BYTE_W-1:0] u_h, v_h, y0_h, y1_h;
  logic              pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      u_h    <= '0;
      v_h    <= '0;
      y0_h   <= '0;
      y1_h   <= '0;
      pend   <= 1'b0;
      px_vld <= 1'b0;
      px     <= '0;
    end else if (word_vld && word_odd) begin
      v_h    <= word[WORD_W-1:BYTE_W];
      y1_h   <= word[BYTE_W-1:0];
      pend   <= 1'b1;
      px_vld <= 1'b1;
      px     <= '{y: y0_h, u: u_h, v: word[WORD_W-1:BYTE_W]};
    end else begin
      if (word_vld) begin
        u_h  <= word[WORD_W-1:BYTE_W];
        y0_h <= word[BYTE_W-1:0];
      end
      pend   <= 1'b0;
      px_vld <= pend;
      if (pend) px <= '{y: y1_h, u: u_h, v: v_h};
    end
  end
endmodule

// File: rtl/pingpong_deinterlace.sv
module pingpong_deinterlace
  import lb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_line_start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              out_line_start,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_y,
  output logic [BYTE_W-1:0] out_u,
  output logic [BYTE_W-1:0] out_v
);
  localparam int NBANK = 2;

  logic              wr_sel, rd_sel, we, have_line;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [WORD_W-1:0] wdata;
  logic [ADDR_W:0]   rd_len;
  logic              word_vld, word_odd;
  logic [NBANK-1:0]  bank_we;
  logic [WORD_W-1:0] bank_rdata [NBANK];
  yuv_px_t           px;

  lb_write_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .line_start(in_line_start),
    .byte_vld(in_valid), .byte_in(in_byte),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .wr_ptr(wr_ptr),
    .we(we), .wdata(wdata), .rd_len(rd_len), .have_line(have_line)
  );

  lb_read_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .start(out_line_start), .have_line(have_line),
    .rd_len(rd_len), .rd_ptr(rd_ptr),
    .word_vld(word_vld), .word_odd(word_odd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              sel_w;
    logic [ADDR_W-1:0] addr;
    assign sel_w      = (wr_sel == 1'(b));
    assign addr       = sel_w ? wr_ptr : rd_ptr;
    assign bank_we[b] = we & sel_w;
    lb_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
      .clk(clk), .we(bank_we[b]), .addr(addr),
      .wdata(wdata), .rdata(bank_rdata[b])
    );
  end

  lb_expand u_exp (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_odd(word_odd),
    .word(bank_rdata[rd_sel]), .px_vld(out_valid), .px(px)
  );

  assign out_y = px.y;
  assign out_u = px.u;
  assign out_v = px.v;
endmodule

// File: rtl/pingpong_deinterlace_chk.sv
module pingpong_deinterlace_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start,
  input logic              out_valid,
  input logic              wr_sel,
  input logic              rd_sel,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [1:0]        bank_we
);
  logic [1:0] starts_seen;

  always_ff @(posedge clk) begin
    if (rst) starts_seen <= '0;
    else if (line_start && starts_seen != 2'd2) starts_seen <= starts_seen + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !out_valid);

  a_r2_no_early_output: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> starts_seen == 2'd2);

  a_r8_swap_roles: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (wr_sel != $past(wr_sel)) && (rd_sel == $past(wr_sel)));

  a_r8_single_bank_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));

  a_r9_ptr_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> wr_ptr >= $past(wr_ptr));
endmodule

bind pingpong_deinterlace pingpong_deinterlace_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .line_start(in_line_start), .out_valid(out_valid),
  .wr_sel(wr_sel), .rd_sel(rd_sel), .wr_ptr(wr_ptr), .bank_we(bank_we)
);

// File: tb/sim_pingpong_deinterlace.sv
module sim_pingpong_deinterlace;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ils = 1'b0, ivld = 1'b0, ols = 1'b0;
  logic [7:0] ibyte = '0;
  logic       ovld;
  logic [7:0] oy, ou, ov;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] ew [0:63];
  int ew_n;
  logic [7:0] cap_y [0:255], cap_u [0:255], cap_v [0:255];
  int cap_c [0:255];
  int cap_n = 0;

  always #10 clk = ~clk;

  pingpong_deinterlace #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .in_line_start(ils), .in_valid(ivld), .in_byte(ibyte),
    .out_line_start(ols), .out_valid(ovld), .out_y(oy), .out_u(ou), .out_v(ov)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ovld && cap_n < 256) begin
      cap_y[cap_n] = oy; cap_u[cap_n] = ou; cap_v[cap_n] = ov;
      cap_c[cap_n] = cyc; cap_n++;
    end
  end

  function automatic logic [7:0] bval(input int line, input int i);
    return 8'((line * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected stored words of a line, with pointer saturation (R9)
  task automatic build(input int line, input int nb);
    ew_n = 0;
    for (int w = 0; w < nb / 2; w++) begin
      int idx = (w < DEPTH) ? w : DEPTH - 1;
      ew[idx] = {bval(line, 2 * w), bval(line, 2 * w + 1)};
      ew_n = (w + 1 < DEPTH) ? w + 1 : DEPTH;
    end
  endtask

  task automatic line_start();
    @(negedge clk); ils = 1'b1;
    @(negedge clk); ils = 1'b0;
  endtask

  // bytes with idle gaps on in_valid (R10)
  task automatic wr_line(input int line, input int nb);
    for (int i = 0; i < nb; i++) begin
      if (i % 3 == 2) begin
        @(negedge clk); ivld = 1'b0; ibyte = 8'hA5;
      end
      @(negedge clk); ivld = 1'b1; ibyte = bval(line, i);
    end
    @(negedge clk); ivld = 1'b0;
  endtask

  task automatic pass(input string tag);
    int base = cap_n;
    int t0;
    @(negedge clk); ols = 1'b1; t0 = cyc;
    @(negedge clk); ols = 1'b0;
    repeat (ew_n + 8) @(negedge clk);
    check({tag, " R5 count"}, cap_n - base == ew_n, cap_n - base, ew_n);
    if (cap_n - base == ew_n && ew_n > 0) begin
      check({tag, " R6 latency"}, cap_c[base] == t0 + 4, cap_c[base], t0 + 4);
      for (int p = 0; p < ew_n; p++) begin
        int q = p / 2;
        logic [15:0] w0 = ew[2 * q];
        logic [15:0] w1 = ew[2 * q + 1];
        logic [7:0] ey = p[0] ? w1[7:0] : w0[7:0];
        check({tag, " R4 contiguous"}, cap_c[base + p] == cap_c[base] + p,
              cap_c[base + p], cap_c[base] + p);
        check({tag, " R3 R4 y"}, cap_y[base + p] == ey, cap_y[base + p], ey);
        check({tag, " R4 u"}, cap_u[base + p] == w0[15:8], cap_u[base + p], w0[15:8]);
        check({tag, " R4 v"}, cap_v[base + p] == w1[15:8], cap_v[base + p], w1[15:8]);
      end
    end
  endtask

  task automatic no_output(input string tag);
    int base = cap_n;
    @(negedge clk); ols = 1'b1;
    @(negedge clk); ols = 1'b0;
    repeat (12) @(negedge clk);
    check(tag, cap_n == base, cap_n - base, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", ovld == 1'b0, ovld, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", ovld == 1'b0, ovld, 0);
    no_output("R2 no line yet");

    line_start();
    wr_line(0, 12);
    no_output("R2 line not closed");

    line_start();
    build(0, 12);
    fork
      wr_line(1, 16);
      begin pass("R8 L0 first"); pass("R7 L0 replay"); end
    join

    line_start();
    build(1, 16);
    fork
      wr_line(2, 40);
      begin pass("R8 L1 first"); pass("R7 L1 replay"); end
    join

    line_start();
    build(2, 40);
    fork
      wr_line(3, 9);
      pass("R9 saturated line");
    join

    line_start();
    build(3, 9);
    fork
      wr_line(4, 8);
      pass("R11 odd line");
    join

    line_start();
    build(4, 8);
    pass("R11 realigned line");
    pass("R7 realigned replay");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule